// File: doc/BRIEF.md
# Conversion Timing Sequencer

This block is the timing engine of an oversampling converter. Each operation is one of four kinds: a single settled conversion, a run of continuous conversions, an offset calibration or a gain calibration. The sequencer counts master-clock cycles for the requested operation and raises a one-cycle completion pulse when it ends. The count depends on the operation, on a 4-bit rate code and on a clock-ratio select. Tag outputs travel with that pulse. They say whether a result may be used, whether the conversion was the long first one of a continuous run, and whether the offset or gain coefficient register should be written.

Continuous runs keep going at a steady period until the host asks them to stop. A single conversion, a calibration or a channel change leaves stale filter state behind. After any of these, the following continuous results are tagged unusable until the filter has been flushed. For simulation, a shift parameter divides every cycle count by a power of two. The scaled length is the unscaled count shifted right by `SHIFT`, with a minimum of one cycle.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, busy, done, result_valid, long_first, wr_offset and wr_gain are all low.
- R2: With op_sel=00 (single), done pulses exactly L cycles after the edge that accepts start. L is max(1, N>>SHIFT), where N comes from the rate's single-conversion count for the selected frs. result_valid pulses with done, and busy is low once done is seen.
- R3: With op_sel=10 (offset calibration), N is the single-conversion count minus 608 (frs=0) or minus 729 (frs=1). wr_offset pulses with done, and result_valid stays low.
- R4: With op_sel=11 (gain calibration), N is the single-conversion count minus 128 (frs=0) or minus 153 (frs=1). wr_gain pulses with done, and result_valid stays low.
- R5: With op_sel=01 (continuous), the first done comes after the first-conversion count for the rate, and long_first pulses with that done only.
- R6: Later continuous periods are steady. For codes 0000..0100 with frs=0 they are 40960 shifted left by the code. For codes 1000..1100 they are 1280 shifted left by (code-8). With frs=1 each steady period is six fifths of its frs=0 value.
- R7: Any rate code outside 0000..0100 and 1000..1100 times exactly like code 0000.
- R8: A completed single conversion or calibration, or a chan_change pulse, marks the next three continuous results invalid (result_valid low on their done). Continuous results after that carry result_valid high.
- R9: A start pulse while busy is ignored: the running operation keeps its timing and its tags.
- R10: stop while a continuous run is busy ends the run. busy is low after that edge and no further done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation (used only when idle) |
| op_sel | input | 2 | 00 single, 01 continuous, 10 offset cal, 11 gain cal |
| rate_code | input | 4 | Output word rate code |
| frs | input | 1 | Clock-ratio select (1 gives 1.2x slower timing) |
| chan_change | input | 1 | Pulse: input channel switched; arms result discard |
| stop | input | 1 | Ends a running continuous operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result_valid | output | 1 | Completed conversion is usable |
| long_first | output | 1 | Completed conversion was the first of a continuous run |
| wr_offset | output | 1 | Strobe: store offset coefficient |
| wr_gain | output | 1 | Strobe: store gain coefficient |

## Verification
The hardest state to reach is the discard window meeting a continuous run. The run must follow a single conversion, a calibration or a channel change. It must then last long enough to cross from the three flushed results to valid ones, and a later run must pick up whatever discard count is still pending. The stimulus mixes random operations with chan_change pulses and continuous runs of random length. A bench model of the pending discard count tracks every step, so both carried-over and freshly armed windows get compared. A start pulse injected mid-operation covers the ignored-request case.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CNT_W = 22;

    typedef enum logic [1:0] {
        OP_SINGLE  = 2'd0,
        OP_CONT    = 2'd1,
        OP_OFFCAL  = 2'd2,
        OP_GAINCAL = 2'd3
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [3:0] rate;
        logic       frs;
    } req_t;

    // Map the rate code to a dense index 0..9; unlisted codes fold onto 0000.
    function automatic logic [3:0] rate_idx(input logic [3:0] r);
        if (r <= 4'd4)
            return r;
        else if (r >= 4'd8 && r <= 4'd12)
            return r - 4'd3;
        else
            return 4'd0;
    endfunction

    function automatic logic [31:0] single_cycles(input logic [3:0] i, input logic f);
        case ({f, i})
            5'h00: return 32'd171448;   5'h10: return 32'd205738;
            5'h01: return 32'd335288;   5'h11: return 32'd402346;
            5'h02: return 32'd662968;   5'h12: return 32'd795562;
            5'h03: return 32'd1318328;  5'h13: return 32'd1581994;
            5'h04: return 32'd2629048;  5'h14: return 32'd3154858;
            5'h05: return 32'd7592;     5'h15: return 32'd9110;
            5'h06: return 32'd17848;    5'h16: return 32'd21418;
            5'h07: return 32'd28088;    5'h17: return 32'd33706;
            5'h08: return 32'd48568;    5'h18: return 32'd58282;
            5'h09: return 32'd89528;    5'h19: return 32'd107434;
            default: return 32'd171448;
        endcase
    endfunction

    function automatic logic [31:0] first_cycles(input logic [3:0] i, input logic f);
        case ({f, i})
            5'h00: return 32'd89528;    5'h10: return 32'd107434;
            5'h01: return 32'd171448;   5'h11: return 32'd205738;
            5'h02: return 32'd335288;   5'h12: return 32'd402346;
            5'h03: return 32'd662968;   5'h13: return 32'd795562;
            5'h04: return 32'd1318328;  5'h14: return 32'd1581994;
            5'h05: return 32'd2472;     5'h15: return 32'd2966;
            5'h06: return 32'd12728;    5'h16: return 32'd15274;
            5'h07: return 32'd17848;    5'h17: return 32'd21418;
            5'h08: return 32'd28088;    5'h18: return 32'd33706;
            5'h09: return 32'd48568;    5'h19: return 32'd58282;
            default: return 32'd89528;
        endcase
    endfunction

    // Steady periods are power-of-two multiples of two bases; frs scales by 6/5.
    function automatic logic [31:0] steady_cycles(input logic [3:0] i, input logic f);
        logic [31:0] base;
        base = (i < 4'd5) ? (32'd40960 << i) : (32'd1280 << (i - 4'd5));
        return f ? (base * 32'd6) / 32'd5 : base;
    endfunction

    function automatic logic [31:0] cal_trim(input op_e op, input logic f);
        if (op == OP_OFFCAL)
            return f ? 32'd729 : 32'd608;
        else
            return f ? 32'd153 : 32'd128;
    endfunction

endpackage

// File: rtl/adc_seq_len.sv
module adc_seq_len
    import adc_seq_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  req_t             req,
    input  logic             first,
    output logic [CNT_W-1:0] len
);
    logic [3:0]  idx;
    logic [31:0] raw;
    logic [31:0] scaled;

    always_comb begin
        idx = rate_idx(req.rate);
        case (req.op)
            OP_SINGLE: raw = single_cycles(idx, req.frs);
            OP_CONT:   raw = first ? first_cycles(idx, req.frs)
                                   : steady_cycles(idx, req.frs);
            default:   raw = single_cycles(idx, req.frs) - cal_trim(req.op, req.frs);
        endcase
        scaled = raw >> SHIFT;
        len    = (scaled == 32'd0) ? CNT_W'(1) : scaled[CNT_W-1:0];
    end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/adc_seq_discard.sv
module adc_seq_discard #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic consume,
    output logic clean
);
    localparam int W = $clog2(DEPTH + 1);
    logic [W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else if (arm)
            pend <= W'(DEPTH);
        else if (consume && pend != '0)
            pend <= pend - W'(1);
    end

    assign clean = (pend == '0);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int SHIFT   = 0,
    parameter int DISCARD = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] op_sel,
    input  logic [3:0] rate_code,
    input  logic       frs,
    input  logic       chan_change,
    input  logic       stop,
    output logic       busy,
    output logic       done,
    output logic       result_valid,
    output logic       long_first,
    output logic       wr_offset,
    output logic       wr_gain
);
    req_t             req_in, req_q;
    logic             busy_q, first_q;
    logic [CNT_W-1:0] start_len, reload_len, load_val;
    logic             zero, clean;
    logic             accept, fire, halt, in_cont;

    assign req_in  = '{op: op_e'(op_sel), rate: rate_code, frs: frs};
    assign in_cont = (req_q.op == OP_CONT);
    assign accept  = start && !busy_q;
    assign halt    = busy_q && in_cont && stop;
    assign fire    = busy_q && zero && !halt;

    adc_seq_len #(.SHIFT(SHIFT)) u_len_start (
        .req(req_in), .first(1'b1), .len(start_len)
    );
    adc_seq_len #(.SHIFT(SHIFT)) u_len_reload (
        .req(req_q), .first(1'b0), .len(reload_len)
    );

    assign load_val = accept ? start_len : reload_len;

    adc_seq_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst),
        .load(accept || (fire && in_cont)),
        .val(load_val), .zero(zero)
    );

    adc_seq_discard #(.DEPTH(DISCARD)) u_discard (
        .clk(clk), .rst(rst),
        .arm(chan_change || (fire && !in_cont)),
        .consume(fire && in_cont),
        .clean(clean)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q       <= 1'b0;
            first_q      <= 1'b0;
            req_q        <= '{op: OP_SINGLE, rate: 4'd0, frs: 1'b0};
            done         <= 1'b0;
            result_valid <= 1'b0;
            long_first   <= 1'b0;
            wr_offset    <= 1'b0;
            wr_gain      <= 1'b0;
        end else begin
            done         <= fire;
            wr_offset    <= fire && (req_q.op == OP_OFFCAL);
            wr_gain      <= fire && (req_q.op == OP_GAINCAL);
            long_first   <= fire && in_cont && first_q;
            result_valid <= fire && ((req_q.op == OP_SINGLE) || (in_cont && clean));
            if (accept) begin
                busy_q  <= 1'b1;
                req_q   <= req_in;
                first_q <= (req_in.op == OP_CONT);
            end else if (halt) begin
                busy_q <= 1'b0;
            end else if (fire) begin
                if (in_cont)
                    first_q <= 1'b0;
                else
                    busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic result_valid,
    input logic long_first,
    input logic wr_offset,
    input logic wr_gain
);
    // R3 R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_offset, wr_gain, result_valid}));

    // R3
    off_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_offset |-> done);

    // R4
    gain_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_gain |-> done);

    // R5
    first_tag_chk: assert property (@(posedge clk) disable iff (rst)
        long_first |-> done);

    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    // R9
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .result_valid(result_valid), .long_first(long_first),
    .wr_offset(wr_offset), .wr_gain(wr_gain)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic [3:0] rate_code = 4'd0;
    logic       frs = 1'b0;
    logic       chan_change = 1'b0;
    logic       stop = 1'b0;
    logic       busy, done, result_valid, long_first, wr_offset, wr_gain;

    int n_chk = 0;
    int n_bad = 0;
    int disc  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_top #(.SHIFT(SH)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .rate_code(rate_code), .frs(frs), .chan_change(chan_change),
        .stop(stop), .busy(busy), .done(done), .result_valid(result_valid),
        .long_first(long_first), .wr_offset(wr_offset), .wr_gain(wr_gain)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int idx_of(input int code);
        if (code <= 4) return code;
        if (code >= 8 && code <= 12) return code - 3;
        return 0;
    endfunction

    function automatic int ref_single(input int code, input int f);
        int t0 [10] = '{171448, 335288, 662968, 1318328, 2629048,
                        7592, 17848, 28088, 48568, 89528};
        int t1 [10] = '{205738, 402346, 795562, 1581994, 3154858,
                        9110, 21418, 33706, 58282, 107434};
        return f ? t1[idx_of(code)] : t0[idx_of(code)];
    endfunction

    function automatic int ref_first(input int code, input int f);
        int t0 [10] = '{89528, 171448, 335288, 662968, 1318328,
                        2472, 12728, 17848, 28088, 48568};
        int t1 [10] = '{107434, 205738, 402346, 795562, 1581994,
                        2966, 15274, 21418, 33706, 58282};
        return f ? t1[idx_of(code)] : t0[idx_of(code)];
    endfunction

    function automatic int ref_steady(input int code, input int f);
        int i = idx_of(code);
        int b = (i < 5) ? (40960 << i) : (1280 << (i - 5));
        return f ? b * 6 / 5 : b;
    endfunction

    function automatic int scl(input int raw);
        int s = raw >> SH;
        return (s == 0) ? 1 : s;
    endfunction

    // Count edges from acceptance until done; optional start injected mid-run.
    task automatic wait_done(input int limit, input int inject, output int got);
        got = 0;
        for (int k = 1; k <= limit + 20; k++) begin
            @(posedge clk); #1;
            if (k == inject) begin start = 1'b1; op_sel = 2'd3; end
            else start = 1'b0;
            if (done) begin got = k; break; end
        end
        start = 1'b0;
    endtask

    task automatic launch(input int op, input int code, input int f);
        @(negedge clk);
        start = 1'b1; op_sel = op[1:0]; rate_code = code[3:0]; frs = f[0];
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic run_oneshot(input int op, input int code, input int f, input int inject);
        int raw, len, got;
        string tag;
        raw = ref_single(code, f);
        tag = "R2";
        if (op == 2) begin raw -= (f ? 729 : 608); tag = "R3"; end
        if (op == 3) begin raw -= (f ? 153 : 128); tag = "R4"; end
        len = scl(raw);
        launch(op, code, f);
        wait_done(len, inject, got);
        if (code > 12 || (code > 4 && code < 8))
            chk(got == len, "R7 unlisted code timing", got, len);
        else
            chk(got == len, {tag, " done timing"}, got, len);
        if (inject > 0) chk(got == len, "R9 start while busy ignored", got, len);
        chk(result_valid == (op == 0), {tag, " result_valid"}, result_valid, op == 0);
        chk(wr_offset == (op == 2), "R3 wr_offset strobe", wr_offset, op == 2);
        chk(wr_gain == (op == 3), "R4 wr_gain strobe", wr_gain, op == 3);
        chk(long_first == 0, "R5 no long_first outside continuous", long_first, 0);
        @(negedge clk);
        chk(busy == 0, "R2 idle after done", busy, 0);
        disc = 3;
    endtask

    task automatic run_cont(input int code, input int f, input int periods);
        int got, len;
        launch(1, code, f);
        for (int p = 0; p < periods; p++) begin
            len = (p == 0) ? scl(ref_first(code, f)) : scl(ref_steady(code, f));
            wait_done(len, -1, got);
            if (p == 0) begin
                chk(got == len, "R5 first continuous period", got, len);
                chk(long_first == 1, "R5 long_first on first done", long_first, 1);
            end else begin
                chk(got == len, "R6 steady continuous period", got, len);
                chk(long_first == 0, "R5 long_first only once", long_first, 0);
            end
            chk(result_valid == (disc == 0), "R8 discard window", result_valid, disc == 0);
            if (disc > 0) disc--;
        end
        // stop one cycle after the last done
        stop = 1'b1;
        @(posedge clk); #1;
        stop = 1'b0;
        chk(busy == 0, "R10 busy low after stop", busy, 0);
        got = 0;
        for (int k = 0; k < 120; k++) begin
            @(posedge clk); #1;
            if (done) got++;
        end
        chk(got == 0, "R10 no done after stop", got, 0);
    endtask

    task automatic pulse_chan();
        @(negedge clk); chan_change = 1'b1;
        @(negedge clk); chan_change = 1'b0;
        disc = 3;
    endtask

    initial begin
        int fast [5] = '{8, 9, 10, 11, 12};
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        chk({busy, done, result_valid, long_first, wr_offset, wr_gain} == 6'b0,
            "R1 reset state", {busy, done, result_valid, long_first, wr_offset, wr_gain}, 0);

        // directed corners
        run_cont(8, 0, 4);            // R8 nothing armed after reset: all valid
        run_oneshot(0, 8, 0, -1);     // R2
        run_oneshot(0, 4, 0, -1);     // R2 slowest code
        run_oneshot(0, 9, 1, 3);      // R9 inject
        run_oneshot(2, 10, 0, -1);    // R3
        run_oneshot(2, 10, 1, -1);    // R3
        run_oneshot(3, 11, 0, -1);    // R4
        run_oneshot(3, 11, 1, 5);     // R4 + R9
        run_oneshot(0, 15, 1, -1);    // R7
        run_oneshot(0, 6, 0, -1);     // R7
        run_cont(12, 1, 5);           // R6 frs=1, R8 armed
        pulse_chan();
        run_cont(9, 0, 2);            // R8 partial window
        run_cont(9, 0, 3);            // R8 carried-over window

        for (int it = 0; it < 30; it++) begin
            int op = $urandom % 5;
            int code = fast[$urandom % 5];
            int f = $urandom % 2;
            if ($urandom % 6 == 0) code = 5 + ($urandom % 3) * 5;  // 5, 10 or 15
            case (op)
                0, 2, 3: run_oneshot(op, code, f, ($urandom % 3 == 0) ? 2 : -1);
                1: run_cont(code, f, 1 + $urandom % 5);
                default: pulse_chan();
            endcase
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule